// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave that lets a host read and write a small bank of control registers of differing widths. Every transfer opens with one instruction byte. The instruction holds a direction flag and a register address. A data phase follows, and its length in bytes is looked up from the width of the register that was addressed. When the last data byte of an access has passed, the port expects another instruction byte right away. The host can therefore chain any number of accesses inside one chip-select window.

The pads are sampled with the block's own clock. The serial clock, chip select and data input each pass through a two-stage synchronizer. The port acts on each detected rising edge of the serial clock to take in a bit. It updates its output bit on each detected falling edge. Read data can leave on a dedicated output line (3-wire mode). It can also be turned around onto the shared data line (2-wire mode), which the block controls through an output enable. All register contents are presented in parallel on one flat vector for the logic that consumes them.

Top module: `sreg_port`

## Requirements
- R1: Bits travel most-significant first. The first eight serial-clock rising edges after chip select falls form the instruction byte. Instruction bit 7 set means read and clear means write, and bits 4:0 give the register address.
- R2: The data phase carries exactly as many bytes as the addressed register is wide: address 0 has 4 bytes, 1 has 3, 2 has 1, 3 has 2 and 4 has 4. Within `regs_o` the registers are packed from bit 0 upward in address order, so register 0 sits at bits 31:0, 1 at 55:32, 2 at 63:56, 3 at 79:64 and 4 at 111:80. The first data byte received lands in the register's most significant byte.
- R3: A write changes the target register only after its final data byte has arrived. Partial data never shows on `regs_o`.
- R4: After the last data byte of an access, the next eight rising edges are taken as a new instruction byte, with no chip-select toggle needed.
- R5: Raising chip select at any point abandons the access in progress without writing. The next low period starts again with an instruction byte.
- R6: An address of 5 or higher is handled as a 1-byte access. Writing it changes no register, and reading it returns zero.
- R7: In 3-wire mode (`two_wire_i` low), read data appears on `sdo_o`, with each bit updated after a serial-clock falling edge. The level on `sdio_i` during a read data phase changes no register.
- R8: In 2-wire mode (`two_wire_i` high), read data is driven on `sdio_o`. `sdio_oe_o` is high only during the data phase of a read, and `sdo_oe_o` stays low.
- R9: `sdo_oe_o` is low whenever chip select is high. In 3-wire mode it is high while chip select is low.
- R10: After reset every register reads zero and both output enables are low.
- R11: Instruction bits 6:5 have no effect on direction, address or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| two_wire_i | input | 1 | 1: reads are driven back on the shared data line; 0: reads use `sdo_o` |
| csn_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data input from the shared pad |
| sdio_o | output | 1 | Read data toward the shared pad |
| sdio_oe_o | output | 1 | Output enable for the shared pad |
| sdo_o | output | 1 | Read data on the dedicated output |
| sdo_oe_o | output | 1 | Output enable for the dedicated output |
| regs_o | output | 112 | All registers, packed as given in R2 |

## Verification
A wrong bit or byte count in the frame state shows up at the ports within one access. The next instruction is decoded from shifted bits, so a later read returns the wrong register, or a later write lands at the wrong address and shows on `regs_o`. A wrong width lookup is caught by chaining accesses inside one chip-select window and then reading a known register. Output-enable and turnaround faults show on the first data bit of the next read, because the bench samples `sdo_o`, `sdio_o` and both enables at each bit.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W    = 5;
  localparam int NUM_REGS  = 5;
  localparam int MAX_BYTES = 4;
  localparam int ACC_W     = MAX_BYTES * 8;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);

  typedef enum logic {PH_INSTR = 1'b0, PH_DATA = 1'b1} phase_e;

  // byte width per address; unmapped addresses behave as one byte
  function automatic int reg_bytes(int idx);
    if (idx >= NUM_REGS) return 1;
    case (idx)
      0:       return 4;
      1:       return 3;
      2:       return 1;
      3:       return 2;
      4:       return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int reg_lsb(int idx);
    int s;
    s = 0;
    for (int i = 0; i < idx; i++) s += reg_bytes(i) * 8;
    return s;
  endfunction

  localparam int BANK_W = reg_lsb(NUM_REGS);
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank import sreg_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ACC_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ACC_W-1:0]  rd_data_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [ACC_W-1:0] rd_arr [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam int W   = reg_bytes(g) * 8;
    localparam int LSB = reg_lsb(g);
    logic [W-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    q <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))    q <= wr_data_i[W-1:0];
    end

    assign bank_o[LSB +: W] = q;
    assign rd_arr[g] = (rd_addr_i == ADDR_W'(g)) ? ACC_W'(q) : '0;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) rd_data_o |= rd_arr[i];
  end

  // R3: contents move only on a commit
  p_hold_without_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(bank_o));
  // R6: commits never target an unmapped address
  p_commit_mapped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_addr_i) < NUM_REGS));
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame import sreg_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  input  logic [ACC_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_en_o,
  output logic [ACC_W-1:0]  wr_data_o,
  output phase_e            phase_o,
  output logic              rd_o,
  output logic              sd_out_o
);
  phase_e            ph_q;
  logic [6:0]        ins_sr;
  logic [7:0]        instr_next;
  logic [2:0]        bit_q;
  logic [LEN_W-1:0]  left_q;
  logic [LEN_W-1:0]  nbytes_c;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  rd_sr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic              out_q;
  logic              wr_en_q;

  assign instr_next = {ins_sr, sdi_i};
  assign nbytes_c   = LEN_W'(reg_bytes(int'(instr_next[ADDR_W-1:0])));
  // read mux must see the address in the same cycle the instruction completes
  assign rd_addr_o  = (ph_q == PH_INSTR) ? instr_next[ADDR_W-1:0] : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_INSTR;
      ins_sr  <= '0;
      bit_q   <= '0;
      left_q  <= '0;
      acc_q   <= '0;
      rd_sr_q <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      out_q   <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (!cs_act_i) begin
        ph_q   <= PH_INSTR;
        bit_q  <= '0;
        left_q <= '0;
        rd_q   <= 1'b0;
        out_q  <= 1'b0;
      end else begin
        if (sclk_rise_i) begin
          bit_q <= bit_q + 3'd1;
          if (ph_q == PH_INSTR) begin
            ins_sr <= instr_next[6:0];
            if (bit_q == 3'd7) begin
              ph_q    <= PH_DATA;
              rd_q    <= instr_next[7];
              addr_q  <= instr_next[ADDR_W-1:0];
              left_q  <= nbytes_c;
              acc_q   <= '0;
              rd_sr_q <= rd_data_i << (ACC_W - 8 * int'(nbytes_c));
            end
          end else begin
            acc_q <= {acc_q[ACC_W-2:0], sdi_i};
            if (bit_q == 3'd7) begin
              left_q <= left_q - LEN_W'(1);
              if (left_q == LEN_W'(1)) begin
                ph_q <= PH_INSTR;
                if (!rd_q && int'(addr_q) < NUM_REGS) wr_en_q <= 1'b1;
              end
            end
          end
        end
        if (sclk_fall_i && ph_q == PH_DATA && rd_q) begin
          out_q   <= rd_sr_q[ACC_W-1];
          rd_sr_q <= {rd_sr_q[ACC_W-2:0], 1'b0};
        end
      end
    end
  end

  assign wr_addr_o = addr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = acc_q;
  assign phase_o   = ph_q;
  assign rd_o      = rd_q;
  assign sd_out_o  = out_q;

  // R5: chip select high forces the instruction phase from bit zero
  p_abort_rearm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (ph_q == PH_INSTR && bit_q == 3'd0));
  // R4: a commit leaves the port ready for a fresh instruction byte
  p_commit_rearms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> (ph_q == PH_INSTR && bit_q == 3'd0));
  // R2: byte count stays within the widest register
  p_len_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_DATA |-> (left_q != '0 && int'(left_q) <= MAX_BYTES));
  // R7: output bit changes only after a falling edge or a deselect
  p_out_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_q) |-> ($past(sclk_fall_i) || $past(!cs_act_i)));
endmodule

// File: rtl/sreg_port.sv
module sreg_port import sreg_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              two_wire_i,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [BANK_W-1:0] regs_o
);
  logic [2:0]        pin_q;
  logic              sclk_prev_q;
  logic              sclk_rise, sclk_fall, cs_act;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [ACC_W-1:0]  rd_data, wr_data;
  logic              wr_en, rd_flag, sd_out;
  phase_e            phase;

  sreg_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({csn_i, sclk_i, sdio_i}),
    .q_o    (pin_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= pin_q[1];
  end

  assign sclk_rise = pin_q[1] & ~sclk_prev_q;
  assign sclk_fall = ~pin_q[1] & sclk_prev_q;
  assign cs_act    = ~pin_q[2];

  sreg_frame i_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (cs_act),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .sdi_i       (pin_q[0]),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .wr_addr_o   (wr_addr),
    .wr_en_o     (wr_en),
    .wr_data_o   (wr_data),
    .phase_o     (phase),
    .rd_o        (rd_flag),
    .sd_out_o    (sd_out)
  );

  sreg_bank i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .bank_o    (regs_o)
  );

  assign sdio_oe_o = two_wire_i & cs_act & (phase == PH_DATA) & rd_flag;
  assign sdo_oe_o  = cs_act & ~two_wire_i;
  assign sdio_o    = sd_out;
  assign sdo_o     = sd_out;

  // R8: turnaround begins only right after an instruction bit was taken
  p_turnaround_after_instr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdio_oe_o) |-> $past(sclk_rise));
  // R8: the two output drivers never overlap
  p_single_driver_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_o && sdo_oe_o));
endmodule

// File: tb/test_sreg_port.sv
module test_sreg_port;
  localparam int H  = 6;
  localparam int BW = 112;
  localparam logic [36:0] VEC [6] = '{
    {5'd0, 32'hDEADBEEF}, {5'd1, 32'h00A1B2C3}, {5'd2, 32'h0000007E},
    {5'd3, 32'h00001234}, {5'd4, 32'h89ABCDEF}, {5'd1, 32'hFF00FF11}
  };

  logic clk = 1'b0, rst_ni = 1'b0, two_wire = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [BW-1:0] regs;
  logic [BW-1:0] exp_bank = '0;
  int checks = 0, errors = 0;
  bit done = 0, oe_instr_seen = 0, oe_data_all = 1, sdo_oe_seen = 0;

  always #4 clk = ~clk;

  sreg_port i_sreg_port (
    .clk_i(clk), .rst_ni(rst_ni), .two_wire_i(two_wire), .csn_i(csn),
    .sclk_i(sclk), .sdio_i(sdio_in), .sdio_o(sdio_o), .sdio_oe_o(sdio_oe),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe), .regs_o(regs)
  );

  function automatic int tb_bytes(int a);
    case (a)
      0: return 4; 1: return 3; 2: return 1; 3: return 2; 4: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int tb_lsb(int a);
    int s = 0;
    for (int i = 0; i < a; i++) s += tb_bytes(i) * 8;
    return s;
  endfunction

  function automatic logic [31:0] field(logic [BW-1:0] v, int a);
    logic [31:0] r = '0;
    if (a < 5) for (int b = 0; b < tb_bytes(a) * 8; b++) r[b] = v[tb_lsb(a) + b];
    return r;
  endfunction

  task automatic model_wr(int a, logic [31:0] d);
    if (a < 5) for (int b = 0; b < tb_bytes(a) * 8; b++) exp_bank[tb_lsb(a) + b] = d[b];
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic xbyte(input logic [7:0] b, input bit in_data, output logic [7:0] rb);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; sdio_in = b[i];
      tick(H);
      rb[i] = two_wire ? sdio_o : sdo_o;
      if (in_data) begin
        if (!sdio_oe) oe_data_all = 0;
      end else if (sdio_oe) oe_instr_seen = 1;
      if (sdo_oe) sdo_oe_seen = 1;
      sclk = 1'b1;
      tick(H);
    end
  endtask

  task automatic xfer(input logic [7:0] ins, input int nb, input logic [31:0] d,
                      output logic [31:0] rd);
    logic [7:0] rb;
    rd = '0;
    xbyte(ins, 1'b0, rb);
    for (int k = nb - 1; k >= 0; k--) begin
      xbyte(d[8*k +: 8], 1'b1, rb);
      rd[8*k +: 8] = rb;
    end
  endtask

  task automatic start_frame();
    csn = 1'b0; tick(H);
  endtask

  task automatic end_frame();
    sclk = 1'b0; tick(H);
    csn = 1'b1; tick(2 * H);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    logic [7:0]  rb;
    tick(3);
    chk(regs == '0, "R10 regs after reset", 128'(regs), 128'(0));
    chk(!sdo_oe && !sdio_oe, "R10 enables after reset", {sdo_oe, sdio_oe}, 0);
    rst_ni = 1'b1;
    tick(4);

    // table: write then read back each vector in 3-wire mode
    for (int v = 0; v < 6; v++) begin
      int a = int'(VEC[v][36:32]);
      logic [31:0] d = VEC[v][31:0];
      start_frame(); xfer({3'b000, 5'(a)}, tb_bytes(a), d, rd); end_frame();
      model_wr(a, d);
      chk(regs == exp_bank, "R2 width write", 128'(regs), 128'(exp_bank));
      start_frame(); xfer({3'b100, 5'(a)}, tb_bytes(a), 32'hFFFF_FFFF, rd); end_frame();
      chk(rd == field(exp_bank, a), "R1 readback msb first", 128'(rd), 128'(field(exp_bank, a)));
      chk(regs == exp_bank, "R7 sdio ignored in read", 128'(regs), 128'(exp_bank));
    end

    // R3: no update before the last byte
    start_frame();
    xbyte(8'h00, 1'b0, rb); xbyte(8'h11, 1'b1, rb); xbyte(8'h22, 1'b1, rb);
    tick(4);
    chk(regs == exp_bank, "R3 partial write hidden", 128'(regs), 128'(exp_bank));
    xbyte(8'h33, 1'b1, rb); xbyte(8'h44, 1'b1, rb);
    end_frame();
    model_wr(0, 32'h11223344);
    chk(regs == exp_bank, "R3 committed after last byte", 128'(regs), 128'(exp_bank));

    // R5: deselect mid-write aborts
    start_frame();
    xbyte(8'h01, 1'b0, rb); xbyte(8'h77, 1'b1, rb);
    end_frame();
    chk(regs == exp_bank, "R5 aborted write", 128'(regs), 128'(exp_bank));
    start_frame(); xfer(8'h01, 3, 32'h00445566, rd); end_frame();
    model_wr(1, 32'h00445566);
    chk(regs == exp_bank, "R5 fresh frame after abort", 128'(regs), 128'(exp_bank));

    // R4: chained accesses in one frame
    start_frame();
    xfer(8'h02, 1, 32'h5A, rd);
    xfer(8'h03, 2, 32'hBEEF, rd);
    xfer(8'h82, 1, 32'h0, rd);
    end_frame();
    model_wr(2, 32'h5A); model_wr(3, 32'hBEEF);
    chk(regs == exp_bank, "R4 chained writes", 128'(regs), 128'(exp_bank));
    chk(rd == 32'h5A, "R4 chained read", 128'(rd), 128'(32'h5A));

    // R6: unmapped address is a one-byte no-op
    start_frame();
    xfer(8'h09, 1, 32'hFF, rd);
    xfer(8'h02, 1, 32'h33, rd);
    xfer(8'h89, 1, 32'h0, rd);
    xfer(8'h83, 2, 32'h0, rd2);
    end_frame();
    model_wr(2, 32'h33);
    chk(regs == exp_bank, "R6 unmapped write", 128'(regs), 128'(exp_bank));
    chk(rd == 32'h0, "R6 unmapped read zero", 128'(rd), 128'(0));
    chk(rd2 == 32'hBEEF, "R6 length one byte", 128'(rd2), 128'(32'hBEEF));

    // R11: bits 6:5 set
    start_frame();
    xfer(8'h64, 4, 32'h13572468, rd);
    xfer(8'hE4, 4, 32'h0, rd);
    end_frame();
    model_wr(4, 32'h13572468);
    chk(regs == exp_bank, "R11 write with spare bits", 128'(regs), 128'(exp_bank));
    chk(rd == 32'h13572468, "R11 read with spare bits", 128'(rd), 128'(32'h13572468));

    // R9: dedicated output enable follows chip select
    chk(!sdo_oe, "R9 sdo off when deselected", 128'(sdo_oe), 0);
    start_frame();
    chk(sdo_oe, "R9 sdo on in 3-wire", 128'(sdo_oe), 1);
    end_frame();

    // R8: 2-wire read turnaround
    two_wire = 1'b1; tick(2);
    oe_instr_seen = 0; oe_data_all = 1; sdo_oe_seen = 0;
    start_frame(); xfer(8'h84, 4, 32'hA5A55A5A, rd); end_frame();
    chk(rd == 32'h13572468, "R8 read on sdio", 128'(rd), 128'(32'h13572468));
    chk(oe_data_all, "R8 sdio_oe during read data", 128'(oe_data_all), 1);
    chk(!oe_instr_seen, "R8 sdio_oe low in instruction", 128'(oe_instr_seen), 0);
    chk(!sdo_oe_seen, "R8 sdo_oe low in 2-wire", 128'(sdo_oe_seen), 0);
    start_frame(); xfer(8'h02, 1, 32'hC3, rd); end_frame();
    model_wr(2, 32'hC3);
    chk(regs == exp_bank, "R8 write in 2-wire", 128'(regs), 128'(exp_bank));
    chk(!sdio_oe, "R8 sdio_oe off after frame", 128'(sdio_oe), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule